// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the processor-side controller that turns an exception request into a change of context, and later undoes it. When a request arrives with a vector number, the sequencer copies the status word and raises its supervisor bit. It then writes a four-word context frame downward onto the supervisor stack, reads a 32-bit handler address from a vector table, and loads that address into the program counter. The vector table starts at a base register that software may rewrite at any time the block is idle, so the table can be moved.

A return command reverses the entry. The sequencer reads the tag word at the top of the stack and checks its layout code. For the one known layout it restores the status word and the program counter from the frame and releases the stack space. Any other code raises an error pulse, and the context is left as it was.

All stack and table traffic uses a single 16-bit memory port. Each access holds its request until the memory answers with ready. The program counter, status word, stack pointer and vector base are loaded through a small configuration write port while the block is idle.

Top module: `exc_seq_top`

## Requirements
- R1: An exception request accepted while idle makes `busy` high from the next cycle until the handler address has been loaded. In that same next cycle, status bit 13 (supervisor) reads 1, and all other status bits are kept.
- R2: Entry writes four words below the supervisor stack pointer, each after first lowering the pointer by 2. The order is: PC[15:0] at SSP-2, PC[31:16] at SSP-4, the status word at SSP-6, and the tag word at SSP-8. The pointer ends at SSP-8.
- R3: The tag word carries the layout code in bits 15:12, which is 0 for this frame, and the vector number times 4 in bits 11:0.
- R4: The status word stored in the frame is the value from before the supervisor bit was raised.
- R5: After the frame, the handler address is read as a high word at VBR + 4*vector and then a low word at VBR + 4*vector + 2. The PC becomes {high, low} and `busy` falls in the cycle the PC is loaded.
- R6: A configuration write with `cfg_sel` = 2 sets the vector base, so the same vector number reaches a different table after relocation. Select 0 writes the PC, 1 writes the status word (data bits 15:0), and 3 writes the stack pointer.
- R7: A return command first reads the tag word at SSP. If its code is 0, the block then reads the status word at SSP+2, PC[31:16] at SSP+4 and PC[15:0] at SSP+6, in that order. It then restores the status word and the PC and sets SSP to SSP+8.
- R8: A tag word whose code is not 0 ends the return after that single read. `fmt_err` is high for exactly one cycle, and the PC, status word and stack pointer keep their values.
- R9: Every memory access holds `mem_req`, `mem_addr` and `mem_wdata` unchanged until a cycle in which `mem_rdy` is high.
- R10: While `busy` is high, configuration writes, exception requests and return commands have no effect. If an exception request and a return command arrive in the same idle cycle, the exception wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_sel | input | 2 | Target: 0 PC, 1 status, 2 vector base, 3 stack pointer |
| cfg_data | input | 32 | Configuration write data |
| exc_req | input | 1 | Exception request |
| exc_vec | input | VEC_W | Vector number of the request |
| ret_req | input | 1 | Return-from-exception command |
| busy | output | 1 | A sequence is running |
| fmt_err | output | 1 | One-cycle pulse: frame layout code not supported |
| pc_q | output | 32 | Program counter |
| sr_q | output | 16 | Status word |
| ssp_q | output | 32 | Supervisor stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory completes the access this cycle |

## Verification
The hardest cases to reach happen in the middle of a sequence. One is a configuration write or a return command that arrives while a stretched memory access is still waiting for ready. The other is a return that finds a frame whose layout code is not 0. The memory model in the bench adds a programmable number of wait states, so a sequence can be held in a known phase while stray writes and commands are driven against it. The bench also places hand-built frames directly into the model's storage, including frames carrying a nonzero code, so the error path is reached without any prior entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 16;
  localparam int OFS_W  = 12;
  localparam int SR_SUPER_BIT = 13;
  localparam logic [3:0] FMT_SHORT = 4'h0;

  localparam logic [1:0] CFG_PC  = 2'd0;
  localparam logic [1:0] CFG_SR  = 2'd1;
  localparam logic [1:0] CFG_VBR = 2'd2;
  localparam logic [1:0] CFG_SSP = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC_HI,
    ST_VEC_LO,
    ST_POP_FMT,
    ST_POP_BODY
  } seq_state_e;
endpackage

// File: rtl/exc_frame_gen.sv
// Combinational frame word selection and vector address formation.
module exc_frame_gen
  import exc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [ADDR_W-1:0] vbr,
  input  logic [VEC_W-1:0]  vec,
  input  logic [ADDR_W-1:0] pc_save,
  input  logic [WORD_W-1:0] sr_save,
  input  logic [1:0]        idx,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [WORD_W-1:0] push_word
);
  localparam int SCALED_W = VEC_W + 2;

  logic [SCALED_W-1:0] vec_scaled;
  logic [OFS_W-1:0]    vec_ofs;

  assign vec_scaled = {vec, 2'b00};
  assign vec_ofs    = OFS_W'(vec_scaled);
  assign vec_addr   = vbr + ADDR_W'(vec_scaled);

  // Push order: PC low, PC high, saved status, tag word.
  always_comb begin
    case (idx)
      2'd0:    push_word = pc_save[15:0];
      2'd1:    push_word = pc_save[31:16];
      2'd2:    push_word = sr_save;
      default: push_word = {FMT_SHORT, vec_ofs};
    endcase
  end
endmodule

// File: rtl/exc_ctx_regs.sv
// Context registers: program counter, status, vector base, stack pointer.
module exc_ctx_regs
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              sr_ld,
  input  logic [WORD_W-1:0] sr_d,
  input  logic              pc_ld,
  input  logic [ADDR_W-1:0] pc_d,
  input  logic              ssp_ld,
  input  logic [ADDR_W-1:0] ssp_d,
  output logic [ADDR_W-1:0] pc_q,
  output logic [WORD_W-1:0] sr_q,
  output logic [ADDR_W-1:0] vbr_q,
  output logic [ADDR_W-1:0] ssp_q
);
  logic [ADDR_W-1:0] pc_nx, vbr_nx, ssp_nx;
  logic [WORD_W-1:0] sr_nx;
  logic              cfg_take;

  assign cfg_take = cfg_en && cfg_wr;

  always_comb begin
    pc_nx  = pc_q;
    sr_nx  = sr_q;
    vbr_nx = vbr_q;
    ssp_nx = ssp_q;
    if (cfg_take) begin
      case (cfg_sel)
        CFG_PC:  pc_nx  = cfg_data;
        CFG_SR:  sr_nx  = cfg_data[WORD_W-1:0];
        CFG_VBR: vbr_nx = cfg_data;
        default: ssp_nx = cfg_data;
      endcase
    end
    // Sequencer loads take precedence over a configuration write.
    if (sr_ld)  sr_nx  = sr_d;
    if (pc_ld)  pc_nx  = pc_d;
    if (ssp_ld) ssp_nx = ssp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sr_q  <= '0;
      vbr_q <= '0;
      ssp_q <= '0;
    end else begin
      pc_q  <= pc_nx;
      sr_q  <= sr_nx;
      vbr_q <= vbr_nx;
      ssp_q <= ssp_nx;
    end
  end

  // R10: the vector base cannot move while a sequence runs
  p_vbr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(vbr_q));
endmodule

// File: rtl/exc_seq_ctrl.sv
// Entry / return sequencing state machine and memory port driver.
module exc_seq_ctrl
  import exc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [WORD_W-1:0] sr_q,
  input  logic [ADDR_W-1:0] vbr_q,
  input  logic [ADDR_W-1:0] ssp_q,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              busy,
  output logic              fmt_err,
  output logic              sr_ld,
  output logic [WORD_W-1:0] sr_d,
  output logic              pc_ld,
  output logic [ADDR_W-1:0] pc_d,
  output logic              ssp_ld,
  output logic [ADDR_W-1:0] ssp_d
);
  localparam logic [WORD_W-1:0] SUPER_MASK = WORD_W'(1) << SR_SUPER_BIT;
  localparam logic [ADDR_W-1:0] WSTEP      = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] FRAME_SZ   = ADDR_W'(8);

  seq_state_e        state, state_nx;
  logic [1:0]        idx, idx_nx;
  logic [VEC_W-1:0]  vec_q, vec_nx;
  logic [WORD_W-1:0] sr_hold, sr_hold_nx;
  logic [ADDR_W-1:0] pc_save, pc_save_nx;
  logic [WORD_W-1:0] hi_q, hi_nx;
  logic              ferr_nx;
  logic [ADDR_W-1:0] vec_addr;
  logic [WORD_W-1:0] push_word;
  logic [ADDR_W-1:0] pop_addr;

  exc_frame_gen #(.VEC_W(VEC_W)) u_frame (
    .vbr       (vbr_q),
    .vec       (vec_q),
    .pc_save   (pc_save),
    .sr_save   (sr_hold),
    .idx       (idx),
    .vec_addr  (vec_addr),
    .push_word (push_word)
  );

  assign pop_addr = ssp_q + ADDR_W'({idx, 1'b0});
  assign busy     = (state != ST_IDLE);

  always_comb begin
    state_nx   = state;
    idx_nx     = idx;
    vec_nx     = vec_q;
    sr_hold_nx = sr_hold;
    pc_save_nx = pc_save;
    hi_nx      = hi_q;
    ferr_nx    = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    sr_ld      = 1'b0;
    sr_d       = sr_q;
    pc_ld      = 1'b0;
    pc_d       = pc_q;
    ssp_ld     = 1'b0;
    ssp_d      = ssp_q;
    case (state)
      ST_IDLE: begin
        if (exc_req) begin
          sr_hold_nx = sr_q;
          pc_save_nx = pc_q;
          vec_nx     = exc_vec;
          sr_ld      = 1'b1;
          sr_d       = sr_q | SUPER_MASK;
          idx_nx     = 2'd0;
          state_nx   = ST_PUSH;
        end else if (ret_req) begin
          state_nx = ST_POP_FMT;
        end
      end
      ST_PUSH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ssp_q - WSTEP;
        mem_wdata = push_word;
        if (mem_rdy) begin
          ssp_ld = 1'b1;
          ssp_d  = ssp_q - WSTEP;
          idx_nx = idx + 2'd1;
          if (idx == 2'd3) state_nx = ST_VEC_HI;
        end
      end
      ST_VEC_HI: begin
        mem_req  = 1'b1;
        mem_addr = vec_addr;
        if (mem_rdy) begin
          hi_nx    = mem_rdata;
          state_nx = ST_VEC_LO;
        end
      end
      ST_VEC_LO: begin
        mem_req  = 1'b1;
        mem_addr = vec_addr + WSTEP;
        if (mem_rdy) begin
          pc_ld    = 1'b1;
          pc_d     = {hi_q, mem_rdata};
          state_nx = ST_IDLE;
        end
      end
      ST_POP_FMT: begin
        mem_req  = 1'b1;
        mem_addr = ssp_q;
        if (mem_rdy) begin
          if (mem_rdata[15:12] != FMT_SHORT) begin
            ferr_nx  = 1'b1;
            state_nx = ST_IDLE;
          end else begin
            idx_nx   = 2'd1;
            state_nx = ST_POP_BODY;
          end
        end
      end
      ST_POP_BODY: begin
        mem_req  = 1'b1;
        mem_addr = pop_addr;
        if (mem_rdy) begin
          case (idx)
            2'd1: begin
              sr_hold_nx = mem_rdata;
              idx_nx     = 2'd2;
            end
            2'd2: begin
              hi_nx  = mem_rdata;
              idx_nx = 2'd3;
            end
            default: begin
              sr_ld    = 1'b1;
              sr_d     = sr_hold;
              pc_ld    = 1'b1;
              pc_d     = {hi_q, mem_rdata};
              ssp_ld   = 1'b1;
              ssp_d    = ssp_q + FRAME_SZ;
              state_nx = ST_IDLE;
            end
          endcase
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      vec_q   <= '0;
      sr_hold <= '0;
      pc_save <= '0;
      hi_q    <= '0;
      fmt_err <= 1'b0;
    end else begin
      state   <= state_nx;
      idx     <= idx_nx;
      vec_q   <= vec_nx;
      sr_hold <= sr_hold_nx;
      pc_save <= pc_save_nx;
      hi_q    <= hi_nx;
      fmt_err <= ferr_nx;
    end
  end

  // R1: acceptance raises busy and the supervisor bit together
  p_accept_super_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && exc_req) |=> (busy && sr_q[SR_SUPER_BIT]));

  // R2: each completed push lowers the stack pointer by one word
  p_push_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH && mem_rdy) |=> (ssp_q == $past(ssp_q) - WSTEP));

  // R5: the low handler word completes the new PC and ends the sequence
  p_handler_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC_LO && mem_rdy) |=> (!busy && pc_q == $past({hi_q, mem_rdata})));

  // R8: a rejected frame leaves the context untouched
  p_bad_fmt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> ($stable(pc_q) && $stable(sr_q) && $stable(ssp_q)));

  // R9: a pending access holds its address and data
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/exc_seq_top.sv
// Exception entry / return sequencer top level.
module exc_seq_top
  import exc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_data,
  input  logic              exc_req,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic              ret_req,
  output logic              busy,
  output logic              fmt_err,
  output logic [31:0]       pc_q,
  output logic [15:0]       sr_q,
  output logic [31:0]       ssp_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_rdy
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [ADDR_W-1:0] vbr_q;
  logic              sr_ld, pc_ld, ssp_ld;
  logic [WORD_W-1:0] sr_d;
  logic [ADDR_W-1:0] pc_d, ssp_d;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  exc_ctx_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_en   (!busy),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .sr_ld    (sr_ld),
    .sr_d     (sr_d),
    .pc_ld    (pc_ld),
    .pc_d     (pc_d),
    .ssp_ld   (ssp_ld),
    .ssp_d    (ssp_d),
    .pc_q     (pc_q),
    .sr_q     (sr_q),
    .vbr_q    (vbr_q),
    .ssp_q    (ssp_q)
  );

  exc_seq_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .exc_req   (exc_req),
    .exc_vec   (exc_vec),
    .ret_req   (ret_req),
    .pc_q      (pc_q),
    .sr_q      (sr_q),
    .vbr_q     (vbr_q),
    .ssp_q     (ssp_q),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .fmt_err   (fmt_err),
    .sr_ld     (sr_ld),
    .sr_d      (sr_d),
    .pc_ld     (pc_ld),
    .pc_d      (pc_d),
    .ssp_ld    (ssp_ld),
    .ssp_d     (ssp_d)
  );
endmodule

// File: tb/sim_exc_seq_top.sv
module sim_exc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_data = '0;
  logic        exc_req = 1'b0;
  logic [7:0]  exc_vec = '0;
  logic        ret_req = 1'b0;
  logic        busy, fmt_err, mem_req, mem_we;
  logic [31:0] pc_q, ssp_q, mem_addr;
  logic [15:0] sr_q, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;

  always #10 clk = ~clk;

  exc_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .exc_req(exc_req), .exc_vec(exc_vec), .ret_req(ret_req), .busy(busy), .fmt_err(fmt_err),
    .pc_q(pc_q), .sr_q(sr_q), .ssp_q(ssp_q), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  // Memory model with programmable wait states and an access log.
  logic [15:0] mem [0:2047];
  logic [31:0] log_addr [0:255];
  logic        log_we   [0:255];
  int          nlog = 0;
  int          wait_n = 0;
  int          wcnt = 0;
  int          hold_err = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic        pre_we = 1'b0;
  logic [31:0] pre_addr = '0;
  logic [15:0] pre_data = '0;

  int checks = 0;
  int fails  = 0;

  always @(negedge clk) begin
    if (pend && (!mem_req || mem_addr != pend_addr)) hold_err = hold_err + 1;
    mem_rdy   = mem_req && (wcnt >= wait_n);
    mem_rdata = mem[mem_addr[11:1]];
  end

  always @(posedge clk) begin
    pend      <= mem_req && !mem_rdy;
    pend_addr <= mem_addr;
    if (pre_we) mem[pre_addr[11:1]] <= pre_data;
    if (mem_req && mem_rdy) begin
      wcnt <= 0;
      if (mem_we) mem[mem_addr[11:1]] <= mem_wdata;
      if (nlog < 256) begin
        log_addr[nlog] <= mem_addr;
        log_we[nlog]   <= mem_we;
      end
      nlog <= nlog + 1;
    end else if (mem_req) begin
      wcnt <= wcnt + 1;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(logic [31:0] a, logic [15:0] d);
    @(negedge clk);
    pre_addr = a; pre_data = d; pre_we = 1'b1;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_ret();
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  // Full entry with frame, order and handler checks (R1..R5, R9).
  task automatic t_entry(logic [7:0] vec, logic [31:0] pc0, logic [15:0] sr0,
                         logic [31:0] ssp0, logic [31:0] vbr, logic [31:0] hnd, int wn);
    int base;
    logic [31:0] va;
    wait_n = wn;
    va = vbr + {22'd0, vec, 2'b00};
    cfg(2'd0, pc0);
    cfg(2'd1, {16'd0, sr0});
    cfg(2'd3, ssp0);
    cfg(2'd2, vbr);
    poke(va, hnd[31:16]);
    poke(va + 32'd2, hnd[15:0]);
    hold_err = 0;
    base = nlog;
    @(negedge clk);
    exc_req = 1'b1; exc_vec = vec;
    @(negedge clk);
    exc_req = 1'b0;
    chk("R1 busy after accept", {31'd0, busy}, 32'd1);
    chk("R1 supervisor bit set", {16'd0, sr_q}, {16'd0, sr0 | 16'h2000});
    wait_idle();
    chk("R5 handler PC", pc_q, hnd);
    chk("R2 final SSP", ssp_q, ssp0 - 32'd8);
    chk("R2 PC low word", {16'd0, mem[(ssp0 - 32'd2) >> 1]}, {16'd0, pc0[15:0]});
    chk("R2 PC high word", {16'd0, mem[(ssp0 - 32'd4) >> 1]}, {16'd0, pc0[31:16]});
    chk("R4 saved status", {16'd0, mem[(ssp0 - 32'd6) >> 1]}, {16'd0, sr0});
    chk("R3 tag word", {16'd0, mem[(ssp0 - 32'd8) >> 1]}, {20'd0, 2'b00, vec, 2'b00});
    chk("R2 access count", nlog - base, 6);
    chk("R2 order w0", log_addr[base],     ssp0 - 32'd2);
    chk("R2 order w3", log_addr[base + 3], ssp0 - 32'd8);
    chk("R2 writes", {31'd0, log_we[base] & log_we[base + 3]}, 32'd1);
    chk("R5 table high addr", log_addr[base + 4], va);
    chk("R5 table low addr", log_addr[base + 5], va + 32'd2);
    chk("R9 hold during wait", hold_err, 0);
  endtask

  // Return from a hand-built frame (R7).
  task automatic t_return(logic [31:0] ssp0, logic [15:0] srf, logic [31:0] pcf, int wn);
    int base;
    wait_n = wn;
    cfg(2'd3, ssp0);
    cfg(2'd0, 32'hDEAD0000);
    cfg(2'd1, 32'h00002700);
    poke(ssp0, 16'h0010);
    poke(ssp0 + 32'd2, srf);
    poke(ssp0 + 32'd4, pcf[31:16]);
    poke(ssp0 + 32'd6, pcf[15:0]);
    base = nlog;
    pulse_ret();
    chk("R7 busy during return", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R7 restored PC", pc_q, pcf);
    chk("R7 restored status", {16'd0, sr_q}, {16'd0, srf});
    chk("R7 SSP released", ssp_q, ssp0 + 32'd8);
    chk("R7 no format error", {31'd0, fmt_err}, 32'd0);
    chk("R7 read count", nlog - base, 4);
    chk("R7 read order 0", log_addr[base], ssp0);
    chk("R7 read order 1", log_addr[base + 1], ssp0 + 32'd2);
    chk("R7 read order 3", log_addr[base + 3], ssp0 + 32'd6);
    chk("R7 reads only", {31'd0, log_we[base] | log_we[base + 3]}, 32'd0);
  endtask

  // Unsupported layout code (R8).
  task automatic t_bad_fmt();
    int base;
    wait_n = 1;
    cfg(2'd0, 32'h0A0B0C0D);
    cfg(2'd1, 32'h00002001);
    cfg(2'd3, 32'h00000500);
    poke(32'h500, 16'h1008);
    base = nlog;
    pulse_ret();
    wait_idle();
    chk("R8 error pulse high", {31'd0, fmt_err}, 32'd1);
    chk("R8 PC kept", pc_q, 32'h0A0B0C0D);
    chk("R8 status kept", {16'd0, sr_q}, 32'h00002001);
    chk("R8 SSP kept", ssp_q, 32'h00000500);
    chk("R8 single read", nlog - base, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'd0, fmt_err}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 no further access", nlog - base, 1);
  endtask

  // Stray writes and commands while busy (R10).
  task automatic t_busy_ignore();
    int base;
    wait_n = 3;
    cfg(2'd3, 32'h00000600);
    cfg(2'd2, 32'h00000100);
    cfg(2'd0, 32'h00001111);
    poke(32'h100 + 32'd20, 16'h0000);
    poke(32'h100 + 32'd22, 16'h4444);
    @(negedge clk);
    exc_req = 1'b1; exc_vec = 8'd5;
    @(negedge clk);
    exc_req = 1'b0;
    repeat (2) @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_data = 32'h00000777;
    ret_req = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_data = 32'h00000300;
    ret_req = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
    wait_idle();
    chk("R10 SSP write ignored", ssp_q, 32'h000005F8);
    chk("R10 base write ignored", pc_q, 32'h00004444);
    base = nlog;
    repeat (4) @(negedge clk);
    chk("R10 return ignored", {31'd0, busy}, 32'd0);
    chk("R10 no access after", nlog - base, 0);
  endtask

  // Exception wins over a simultaneous return (R10).
  task automatic t_priority();
    int base;
    wait_n = 0;
    cfg(2'd3, 32'h00000700);
    base = nlog;
    @(negedge clk);
    exc_req = 1'b1; ret_req = 1'b1; exc_vec = 8'd5;
    @(negedge clk);
    exc_req = 1'b0; ret_req = 1'b0;
    wait_idle();
    chk("R10 entry chosen", log_addr[base], 32'h000006FE);
    chk("R10 first access writes", {31'd0, log_we[base]}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset busy", {31'd0, busy}, 32'd0);
    chk("reset PC", pc_q, 32'd0);
    chk("reset status", {16'd0, sr_q}, 32'd0);
    chk("reset request", {31'd0, mem_req}, 32'd0);
    chk("reset error", {31'd0, fmt_err}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    t_entry(8'd3, 32'h12345678, 16'h0015, 32'h00000400, 32'h00000100, 32'hCAFE0010, 0);
    t_entry(8'd3, 32'h00ABCDEF, 16'h0000, 32'h00000480, 32'h00000600, 32'hBEEF0020, 2);
    chk("R6 relocated table used", pc_q, 32'hBEEF0020);
    t_entry(8'd255, 32'hFFFF0002, 16'h871F, 32'h00000800, 32'h00000000, 32'h00112233, 1);

    // Round trip: the frame written by the last entry is popped back.
    wait_n = 1;
    pulse_ret();
    wait_idle();
    chk("R7 round trip PC", pc_q, 32'hFFFF0002);
    chk("R7 round trip status", {16'd0, sr_q}, 32'h0000871F);
    chk("R7 round trip SSP", ssp_q, 32'h00000800);

    t_return(32'h00000200, 16'h0004, 32'h13572468, 0);
    t_return(32'h00000300, 16'h2012, 32'h00000ACE, 3);
    t_bad_fmt();
    t_busy_ignore();
    t_priority();

    summary();
    $finish;
  end
endmodule